// File: doc/BRIEF.md
# Fault Latch and Automatic Retry Controller

This block sits beside a protected power switch. It drives the switch enable and forces it low as soon as any of four fault requests is seen: overtemperature, breaker trip, timer pin grounded, or current-limit pin grounded. The shutdown is latched. It stays in force after the fault request goes away, until something clears the latch.

Two things clear the latch. The first is an external event: the enable input goes low or the supply undervoltage flag rises. The second is an internal retry sequencer. The sequencer waits out a retry delay and then turns the switch back on. The delay is either a fixed eight cycles or a programmed period. The sequencer counts its retries against a selectable power-of-four limit, or it may retry without limit. When the limit is used up, the next fault parks the block in a terminal latched-off state. If no fault is seen for seven delay periods after the most recent one, the retry count returns to zero. The next fault then starts a fresh sequence.

The controller has four states:

| State | Meaning |
|---|---|
| `ST_OFF` | Disabled by the external reset. |
| `ST_ON` | The switch is conducting. |
| `ST_WAIT` | The latch is set and the retry delay is running. |
| `ST_LOCK` | Terminal latch-off. |

Its transitions are:

| Transition | Condition |
|---|---|
| enable | `ST_OFF`→`ST_ON` when the external reset is gone and no fault is present. |
| trip | `ST_ON`/`ST_OFF`→`ST_WAIT` on a fault while a retry is still allowed. |
| lock | `ST_ON`/`ST_OFF`→`ST_LOCK` on a fault when no retry is allowed. |
| retry | `ST_WAIT`→`ST_ON` when the delay expires. |
| disable | Any state→`ST_OFF` while the enable input is low or the undervoltage flag is high. |

Top module: `fault_retry_ctrl`

## Requirements
- R1: While `rst_n` is low, `sw_en`, `latched_off` and `retry_cnt` are 0. Take a reset released with enable high, undervoltage clear and no fault. On the first rising edge after the release, `sw_en` goes to 1.
- R2: Any single line of `fault_req[3:0]` that is high while the switch is on drives `sw_en` to 0 at the next rising edge. `sw_en` stays 0 after the line drops, for as long as the latch is set.
- R3: A low `enable_in` or a high `uv_flag` is an external reset. At the next edge it forces `sw_en`, `latched_off` and `retry_cnt` to 0, whatever the retry configuration. The retry delay timer and the quiet timer are cleared at the same edge.
- R4: `dly_mode` 2'b00 (and 2'b11) selects latch-off. A fault sets `latched_off` at the next edge and no retry ever follows.
- R5: `dly_mode` 2'b01 selects the minimum delay. After a fault, `sw_en` is 0 for exactly 8 cycles and then returns to 1. `retry_cnt` rises by one at that same edge.
- R6: `dly_mode` 2'b10 selects the programmed delay. `sw_en` is 0 for exactly P cycles, where P is `dly_period` sampled at the edge that sets the latch. A later change to `dly_period` does not alter a delay already running, and P = 0 is treated as 1.
- R7: `cnt_sel` values 0, 1, 2, 3 and 4 set the retry limit to 4, 16, 64, 256 and 1024. A fault that arrives when `retry_cnt` equals the limit enters the terminal state. `latched_off` is then 1 and `sw_en` is 0 until an external reset.
- R8: `cnt_sel` values 5, 6 and 7 mean unlimited retries. The block never latches off in these modes, and `retry_cnt` saturates at 2047.
- R9: Let D be the active delay. If no fault is seen for 7·D cycles from the edge that set the latch, `retry_cnt` returns to 0 at that edge. A later fault then counts from zero again.
- R10: Faults are ignored while the external reset is active. If a fault is present when the reset is released, it is handled as a trip or lock at the first edge after the release, and `sw_en` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_in | input | 1 | Enable level; low disables the block and clears the latch |
| uv_flag | input | 1 | Supply undervoltage; high clears the latch |
| fault_req | input | 4 | Level-sensitive fault requests |
| dly_mode | input | 2 | 00/11 latch-off, 01 minimum delay, 10 programmed delay |
| dly_period | input | 24 | Programmed retry delay in cycles |
| cnt_sel | input | 3 | 0..4 select a limit of 4^(sel+1); 5..7 select unlimited |
| sw_en | output | 1 | Switch enable |
| latched_off | output | 1 | Terminal latch-off status |
| retry_cnt | output | 11 | Retries since the last clear |

## Verification
Some rules are checked by assertions on every cycle:
- a fault while on removes the enable at the next edge;
- an external reset clears all outputs one edge later;
- the terminal state holds until an external reset;
- latch-off mode goes straight to the terminal state;
- the retry count only steps by one or returns to zero;
- unlimited mode never locks;
- the delay and quiet timers stay inside their windows.

Other behaviour only the bench scenarios can show:
- the exact length of the off interval in both delay modes, and that the programmed period is sampled at the latch edge;
- the count at which each limit locks;
- saturation at 2047;
- the 7·D quiet clear;
- a fault that is pending when the reset is released.

// File: rtl/frc_pkg.sv
package frc_pkg;
    localparam int RCNT_W = 11;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_ON,
        ST_WAIT,
        ST_LOCK
    } frc_state_t;

    localparam logic [1:0] DM_LATCH = 2'b00;
    localparam logic [1:0] DM_MIN   = 2'b01;
    localparam logic [1:0] DM_PROG  = 2'b10;
endpackage

// File: rtl/frc_retry_timer.sv
module frc_retry_timer #(
    parameter int PER_W   = 24,
    parameter int MIN_DLY = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic             use_min,
    input  logic [PER_W-1:0] period,
    input  logic             run,
    output logic             expire,
    output logic [PER_W-1:0] dly_len
);
    logic [PER_W-1:0] rem;
    logic [PER_W-1:0] d_val;

    // The delay is sampled here, at the edge that sets the latch (R6).
    always_comb begin
        if (use_min)
            d_val = PER_W'(MIN_DLY);
        else if (period == '0)
            d_val = PER_W'(1);
        else
            d_val = period;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem     <= '0;
            dly_len <= '0;
        end else if (clr) begin
            rem     <= '0;
            dly_len <= '0;
        end else if (load) begin
            rem     <= d_val;
            dly_len <= d_val;
        end else if (run && rem != '0) begin
            rem <= rem - PER_W'(1);
        end
    end

    assign expire = run && (rem == PER_W'(1));

    // The timer never runs empty while the controller waits.
    assert_wait_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> rem != '0);
endmodule

// File: rtl/frc_quiet_timer.sv
module frc_quiet_timer #(
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             restart,
    input  logic             run,
    input  logic [LEN_W-1:0] len,
    output logic             quiet
);
    localparam int QW = LEN_W + 3;

    logic [QW-1:0] win;
    logic [QW-1:0] q;
    logic          at_end;

    assign win    = ({3'b000, len} << 3) - {3'b000, len};
    assign at_end = (len != '0) && (q == win - QW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (clr || restart)
            q <= '0;
        else if (run && !at_end)
            q <= q + QW'(1);
    end

    assign quiet = run && at_end;

    assert_quiet_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (len != '0) |-> q < win);
endmodule

// File: rtl/fault_retry_ctrl.sv
module fault_retry_ctrl
    import frc_pkg::*;
#(
    parameter int N_FAULT = 4,
    parameter int PER_W   = 24,
    parameter int MIN_DLY = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable_in,
    input  logic                 uv_flag,
    input  logic [N_FAULT-1:0]   fault_req,
    input  logic [1:0]           dly_mode,
    input  logic [PER_W-1:0]     dly_period,
    input  logic [2:0]           cnt_sel,
    output logic                 sw_en,
    output logic                 latched_off,
    output logic [RCNT_W-1:0]    retry_cnt
);
    localparam logic [RCNT_W-1:0] CNT_MAX = '1;

    frc_state_t       state, nxt;
    logic             ext_rst, any_fault, fault_ev, retry_mode, retry_ok;
    logic             go_wait, go_lock, expire, quiet, lim_inf;
    logic [RCNT_W-1:0] lim_val;
    logic [PER_W-1:0] dly_len;

    assign ext_rst    = !enable_in || uv_flag;
    assign any_fault  = |fault_req;
    assign fault_ev   = !ext_rst && any_fault && (state == ST_ON || state == ST_OFF);
    assign retry_mode = (dly_mode == DM_MIN) || (dly_mode == DM_PROG);

    always_comb begin
        lim_inf = (cnt_sel > 3'd4);
        lim_val = RCNT_W'(1) << ({1'b0, cnt_sel} * 4'd2 + 4'd2);
    end

    assign retry_ok = retry_mode && (lim_inf || retry_cnt < lim_val);
    assign go_wait  = fault_ev && retry_ok;
    assign go_lock  = fault_ev && !retry_ok;

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:  nxt = go_wait ? ST_WAIT : (go_lock ? ST_LOCK : ST_ON);
            ST_ON:   nxt = go_wait ? ST_WAIT : (go_lock ? ST_LOCK : ST_ON);
            ST_WAIT: nxt = expire ? ST_ON : ST_WAIT;
            ST_LOCK: nxt = ST_LOCK;
        endcase
        if (ext_rst)
            nxt = ST_OFF;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= nxt;
    end

    // Retry counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            retry_cnt <= '0;
        else if (ext_rst)
            retry_cnt <= '0;
        else if (state == ST_WAIT && expire) begin
            if (retry_cnt != CNT_MAX)
                retry_cnt <= retry_cnt + RCNT_W'(1);
        end else if (state == ST_ON && quiet && !fault_ev)
            retry_cnt <= '0;
    end

    // Outputs
    always_comb begin
        sw_en       = (state == ST_ON);
        latched_off = (state == ST_LOCK);
    end

    frc_retry_timer #(.PER_W(PER_W), .MIN_DLY(MIN_DLY)) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ext_rst),
        .load    (go_wait),
        .use_min (dly_mode == DM_MIN),
        .period  (dly_period),
        .run     (state == ST_WAIT),
        .expire  (expire),
        .dly_len (dly_len)
    );

    frc_quiet_timer #(.LEN_W(PER_W)) u_quiet (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ext_rst),
        .restart (fault_ev),
        .run     (state == ST_ON || state == ST_WAIT),
        .len     (dly_len),
        .quiet   (quiet)
    );

    assert_fault_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && any_fault && !ext_rst) |=> !sw_en);

    assert_ext_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst |=> (!sw_en && !latched_off && retry_cnt == '0));

    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_off && !ext_rst) |=> latched_off);

    assert_latchoff_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_ev && !retry_mode) |=> latched_off);

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rst |=> (retry_cnt == $past(retry_cnt) ||
                      retry_cnt == $past(retry_cnt) + RCNT_W'(1) ||
                      retry_cnt == '0));

    assert_no_lock_unlimited_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_ev && lim_inf && retry_mode) |=> !latched_off);
endmodule

// File: tb/fault_retry_ctrl_test.sv
module fault_retry_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_in = 1'b1;
    logic        uv_flag = 1'b0;
    logic [3:0]  fault_req = 4'h0;
    logic [1:0]  dly_mode = 2'b00;
    logic [23:0] dly_period = 24'd0;
    logic [2:0]  cnt_sel = 3'd0;
    logic        sw_en, latched_off;
    logic [10:0] retry_cnt;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fault_retry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .enable_in(enable_in), .uv_flag(uv_flag),
        .fault_req(fault_req), .dly_mode(dly_mode), .dly_period(dly_period),
        .cnt_sel(cnt_sel), .sw_en(sw_en), .latched_off(latched_off),
        .retry_cnt(retry_cnt)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ext_reset();
        enable_in = 1'b0;
        step(2);
        enable_in = 1'b1;
        step(2);
    endtask

    task automatic off_len(output int n);
        n = 0;
        while (!sw_en && n < 200) begin
            n++;
            step(1);
        end
    endtask

    task automatic t_reset();
        chk("R1 sw_en in reset", sw_en, 0);
        chk("R1 latched in reset", latched_off, 0);
        chk("R1 count in reset", retry_cnt, 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 sw_en after release", sw_en, 1);
    endtask

    task automatic t_latchoff();
        dly_mode = 2'b00;
        for (int i = 0; i < 4; i++) begin
            fault_req = 4'(1 << i);
            step(1);
            chk("R2 sw_en drops", sw_en, 0);
            chk("R4 latched", latched_off, 1);
            fault_req = 4'h0;
            step(4);
            chk("R2 held after fault clear", sw_en, 0);
            chk("R4 no retry", latched_off, 1);
            if (i == 3) begin
                uv_flag = 1'b1;
                step(1);
                uv_flag = 1'b0;
            end else begin
                enable_in = 1'b0;
                step(1);
                enable_in = 1'b1;
            end
            chk("R3 latch cleared", latched_off, 0);
            chk("R3 sw_en low", sw_en, 0);
            step(1);
            chk("R3 sw_en back", sw_en, 1);
        end
        dly_mode = 2'b11;
        fault_req = 4'h1;
        step(1);
        fault_req = 4'h0;
        step(10);
        chk("R4 mode 11 latched", latched_off, 1);
        ext_reset();
    endtask

    task automatic t_min_delay();
        int n;
        dly_mode = 2'b01;
        cnt_sel = 3'd0;
        fault_req = 4'h2;
        step(1);
        fault_req = 4'h0;
        off_len(n);
        chk("R5 off cycles", n, 8);
        chk("R5 count", retry_cnt, 1);
        ext_reset();
        chk("R3 count cleared", retry_cnt, 0);
    endtask

    task automatic t_prog();
        int n;
        dly_mode = 2'b10;
        cnt_sel = 3'd1;
        dly_period = 24'd20;
        fault_req = 4'h4;
        step(1);
        fault_req = 4'h0;
        dly_period = 24'd5;
        off_len(n);
        chk("R6 off cycles P=20", n, 20);
        chk("R6 count", retry_cnt, 1);
        dly_period = 24'd0;
        step(1);
        fault_req = 4'h8;
        step(1);
        fault_req = 4'h0;
        off_len(n);
        chk("R6 off cycles P=0", n, 1);
        ext_reset();
    endtask

    task automatic t_limit(input logic [2:0] sel, input int lim);
        dly_mode = 2'b01;
        cnt_sel = sel;
        fault_req = 4'h1;
        step(lim * 9 + 30);
        chk("R7 latched at limit", latched_off, 1);
        chk("R7 count at limit", retry_cnt, lim);
        fault_req = 4'h0;
        step(20);
        chk("R7 still latched", latched_off, 1);
        chk("R7 switch off", sw_en, 0);
        ext_reset();
        chk("R3 unlatched", latched_off, 0);
    endtask

    task automatic t_unlimited();
        dly_mode = 2'b01;
        cnt_sel = 3'd6;
        fault_req = 4'h2;
        step(2047 * 9 + 200);
        chk("R8 never latched", latched_off, 0);
        chk("R8 count saturated", retry_cnt, 2047);
        fault_req = 4'h0;
        ext_reset();
    endtask

    task automatic t_quiet();
        int n;
        dly_mode = 2'b01;
        cnt_sel = 3'd0;
        fault_req = 4'h1;
        step(1);
        fault_req = 4'h0;
        step(54);
        chk("R9 count before window", retry_cnt, 1);
        step(2);
        chk("R9 count cleared", retry_cnt, 0);
        fault_req = 4'h1;
        step(1);
        fault_req = 4'h0;
        off_len(n);
        chk("R9 fresh off cycles", n, 8);
        chk("R9 fresh count", retry_cnt, 1);
        ext_reset();
    endtask

    task automatic t_overlap();
        dly_mode = 2'b00;
        enable_in = 1'b0;
        fault_req = 4'h8;
        step(3);
        chk("R10 no latch during reset", latched_off, 0);
        chk("R10 switch off during reset", sw_en, 0);
        enable_in = 1'b1;
        step(1);
        chk("R10 latched on release", latched_off, 1);
        chk("R10 switch never on", sw_en, 0);
        fault_req = 4'h0;
        ext_reset();
        chk("R10 recovers", sw_en, 1);
    endtask

    initial begin
        step(3);
        t_reset();
        step(2);
        t_latchoff();
        t_min_delay();
        t_prog();
        t_limit(3'd0, 4);
        t_limit(3'd1, 16);
        t_limit(3'd2, 64);
        t_limit(3'd4, 1024);
        t_unlimited();
        t_quiet();
        t_overlap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule